// File: doc/BRIEF.md
# I2C Bus SCL-Stall Timeout Detector

This block watches the SCL and SDA lines of a multi-master I2C bus. It reports a stall when SCL stays high for too long while a transfer is in progress. It samples both lines into the system clock domain and tracks START and STOP conditions to keep a bus-busy indication. While the bus is busy and detection is enabled, it measures each unbroken high interval of SCL. If that interval runs past the selected limit, it raises a sticky timeout flag and an interrupt request in the same cycle.

Software chooses one of two limits with a single select bit. The interrupt request can be dropped by an acknowledge strobe or by a software clear strobe, and neither of these touches the flag. To recover, either pull the interface-enable input low or pulse the interface-reset input. Both paths clear the flag, the interval counter and the bus-busy state.

Top module: `i2c_scl_stall_watch`

## Requirements
- R1: After reset, `bus_busy`, `tmo_flag` and `irq_req` are all 0.
- R2: Both bus lines pass through a two-flop synchroniser. A START (SDA falling while SCL is high) sets `bus_busy` on the third clock edge after the SDA change. A STOP (SDA rising while SCL is high) clears `bus_busy` with the same latency.
- R3: With `period_sel`=0, `det_en`=1 and the bus busy, suppose SCL goes high and stays high. `tmo_flag` and `irq_req` both become 1 on the 1027th rising edge after the SCL change (a 1024-cycle limit plus synchroniser latency, counting strictly longer than the limit). They are still 0 one edge earlier.
- R4: With `period_sel`=1 the limit is 2048 cycles, so the flag rises on the 2051st edge after SCL goes high.
- R5: While `bus_busy` is 0, no length of SCL high time sets the flag.
- R6: While `det_en` is 0 the counter is held at zero and no timeout is flagged. Clearing `det_en` during a count restarts the measurement, and `tmo_flag` is left as it was.
- R7: A low level on the synchronised SCL resets the counter, so only one unbroken high interval is measured.
- R8: `irq_ack` or `irq_clr` high at a clock edge clears `irq_req` at that edge and leaves `tmo_flag` unchanged.
- R9: Once set, `tmo_flag` stays 1 even if SCL goes low. The counter saturates, and no new interrupt request is raised until recovery clears the flag.
- R10: `if_en`=0 or `if_rst`=1 at a clock edge clears `tmo_flag`, `bus_busy` and the counter at that edge.
- R11: If a timeout is detected in the same cycle as an `irq_ack` or `irq_clr`, the request is set: the new event wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_in | input | 1 | Raw SCL line level |
| sda_in | input | 1 | Raw SDA line level |
| det_en | input | 1 | Timeout detection enable |
| period_sel | input | 1 | Limit select: 0 = short limit, 1 = long limit |
| irq_ack | input | 1 | Interrupt acknowledge strobe |
| irq_clr | input | 1 | Software clear strobe for the interrupt request |
| if_en | input | 1 | Interface enable; 0 forces recovery |
| if_rst | input | 1 | Interface reset; 1 forces recovery |
| bus_busy | output | 1 | Transfer in progress (between START and STOP) |
| tmo_flag | output | 1 | Sticky SCL-stall flag |
| irq_req | output | 1 | Interrupt request |

## Verification
Two events can land on the same clock edge: the counter reaching the limit, which sets the request, and an acknowledge or software clear, which drops it. The bench counts the exact edge on which the timeout fires from the moment SCL is raised, and holds `irq_ack` high across that edge. It then expects `irq_req` to read 1 afterwards, because the fresh event must not be swallowed. The same exact-edge counting is used to check that the flag is still clear one edge earlier, so an off-by-one in the limit comparison is exposed.

// File: rtl/i2c_scl_stall_watch.sv
module i2c_scl_stall_watch #(
  parameter int SHORT_CYCLES = 1024,
  parameter int LONG_CYCLES  = 2048
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_in,
  input  logic sda_in,
  input  logic det_en,
  input  logic period_sel,
  input  logic irq_ack,
  input  logic irq_clr,
  input  logic if_en,
  input  logic if_rst,
  output logic bus_busy,
  output logic tmo_flag,
  output logic irq_req
);
  localparam int CW = $clog2(LONG_CYCLES + 1);

  logic [1:0]    scl_sy, sda_sy;
  logic          sda_d;
  logic [CW-1:0] cnt;

  wire scl_h   = scl_sy[1];
  wire sda_h   = sda_sy[1];
  wire start_c = scl_h & sda_d & ~sda_h;
  wire stop_c  = scl_h & ~sda_d & sda_h;
  wire recover = ~if_en | if_rst;
  wire run     = det_en & bus_busy & scl_h & ~recover;
  wire [CW-1:0] limit = period_sel ? CW'(LONG_CYCLES) : CW'(SHORT_CYCLES);
  wire hit     = run & ~tmo_flag & (cnt >= limit);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      scl_sy <= 2'b11;
      sda_sy <= 2'b11;
      sda_d  <= 1'b1;
    end else begin
      scl_sy <= {scl_sy[0], scl_in};
      sda_sy <= {sda_sy[0], sda_in};
      sda_d  <= sda_h;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)            bus_busy <= 1'b0;
    else if (recover)      bus_busy <= 1'b0;
    else if (start_c)      bus_busy <= 1'b1;
    else if (stop_c)       bus_busy <= 1'b0;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)            cnt <= '0;
    else if (!run)         cnt <= '0;
    else if (cnt < limit)  cnt <= cnt + 1'b1;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)            tmo_flag <= 1'b0;
    else if (recover)      tmo_flag <= 1'b0;
    else if (hit)          tmo_flag <= 1'b1;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                   irq_req <= 1'b0;
    else if (hit)                 irq_req <= 1'b1;
    else if (irq_ack || irq_clr)  irq_req <= 1'b0;
endmodule

// File: rtl/i2c_scl_stall_watch_chk.sv
module i2c_scl_stall_watch_chk #(
  parameter int LONG_CYCLES = 2048,
  localparam int CW = $clog2(LONG_CYCLES + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          det_en,
  input logic          irq_ack,
  input logic          irq_clr,
  input logic          if_en,
  input logic          if_rst,
  input logic          bus_busy,
  input logic          tmo_flag,
  input logic          irq_req,
  input logic [CW-1:0] cnt
);
  AST_FLAG_WITH_IRQ: assert property (@(posedge clk) disable iff (!rst_n) $rose(tmo_flag) |-> irq_req); // R3
  AST_FREE_BUS_QUIET: assert property (@(posedge clk) disable iff (!rst_n) (!bus_busy && !tmo_flag) |=> !tmo_flag); // R5
  AST_DISABLED_CNT_ZERO: assert property (@(posedge clk) disable iff (!rst_n) !det_en |=> cnt == '0); // R6
  AST_DISABLED_FLAG_KEPT: assert property (@(posedge clk) disable iff (!rst_n) (!det_en && if_en && !if_rst) |=> $stable(tmo_flag)); // R6
  AST_ACK_DROPS_IRQ: assert property (@(posedge clk) disable iff (!rst_n) ((irq_ack || irq_clr) && tmo_flag) |=> !irq_req); // R8
  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n) (tmo_flag && if_en && !if_rst) |=> tmo_flag); // R9
  AST_CNT_SATURATES: assert property (@(posedge clk) disable iff (!rst_n) cnt <= CW'(LONG_CYCLES)); // R9
  AST_RECOVERY_CLEARS: assert property (@(posedge clk) disable iff (!rst_n) (!if_en || if_rst) |=> (!tmo_flag && !bus_busy && cnt == '0)); // R10
endmodule

bind i2c_scl_stall_watch i2c_scl_stall_watch_chk #(.LONG_CYCLES(LONG_CYCLES)) u_chk (
  .clk(clk), .rst_n(rst_n), .det_en(det_en), .irq_ack(irq_ack), .irq_clr(irq_clr),
  .if_en(if_en), .if_rst(if_rst), .bus_busy(bus_busy), .tmo_flag(tmo_flag),
  .irq_req(irq_req), .cnt(cnt)
);

// File: tb/test_i2c_scl_stall_watch.sv
module test_i2c_scl_stall_watch;
  localparam int CLK_PERIOD = 10;
  localparam int T0 = 1024;
  localparam int T1 = 2048;

  logic clk = 1'b0, rst_n = 1'b0;
  logic scl_in = 1'b1, sda_in = 1'b1, det_en = 1'b1, period_sel = 1'b0;
  logic irq_ack = 1'b0, irq_clr = 1'b0, if_en = 1'b1, if_rst = 1'b0;
  logic bus_busy, tmo_flag, irq_req;

  i2c_scl_stall_watch i_i2c_scl_stall_watch (
    .clk(clk), .rst_n(rst_n), .scl_in(scl_in), .sda_in(sda_in), .det_en(det_en),
    .period_sel(period_sel), .irq_ack(irq_ack), .irq_clr(irq_clr), .if_en(if_en),
    .if_rst(if_rst), .bus_busy(bus_busy), .tmo_flag(tmo_flag), .irq_req(irq_req)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  typedef struct {
    int         cyc;
    string      req;
    logic [2:0] val;
    logic [2:0] mask;
  } item_t;

  item_t q[$];
  int cyc_cnt = 0;
  int checks = 0;
  int failures = 0;

  always @(posedge clk) cyc_cnt <= cyc_cnt + 1;

  // monitor: compares {bus_busy, tmo_flag, irq_req} at the scheduled cycle
  always @(negedge clk) begin
    while (q.size() > 0 && q[0].cyc <= cyc_cnt) begin
      item_t it;
      logic [2:0] act;
      it = q.pop_front();
      act = {bus_busy, tmo_flag, irq_req};
      checks++;
      if (((act ^ it.val) & it.mask) != 3'b000 || it.cyc != cyc_cnt) begin
        failures++;
        $display("FAIL %s cycle %0d busy/flag/irq actual=%b expected=%b mask=%b",
                 it.req, cyc_cnt, act, it.val, it.mask);
      end
    end
  end

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic expect_at(string r, int d, logic [2:0] v, logic [2:0] m);
    item_t it;
    it.cyc = cyc_cnt + d;
    it.req = r;
    it.val = v;
    it.mask = m;
    q.push_back(it);
  endtask

  task automatic do_start();
    sda_in = 1'b1; tick(4);
    scl_in = 1'b1; tick(4);
    sda_in = 1'b0; tick(4);
    scl_in = 1'b0; tick(4);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    tick(3);
    rst_n = 1'b1;
    expect_at("R1", 1, 3'b000, 3'b111);
    tick(2);

    sda_in = 1'b0;
    expect_at("R2", 2, 3'b000, 3'b100);
    expect_at("R2", 3, 3'b100, 3'b100);
    tick(4);
    scl_in = 1'b0; tick(4);

    scl_in = 1'b1;
    expect_at("R3", T0 + 2, 3'b100, 3'b111);
    expect_at("R3", T0 + 3, 3'b111, 3'b111);
    tick(T0 + 4);

    scl_in = 1'b0; tick(3);
    expect_at("R9", 1, 3'b011, 3'b011);
    tick(2);
    irq_clr = 1'b1;
    expect_at("R8", 1, 3'b010, 3'b011);
    tick(1); irq_clr = 1'b0; tick(2);
    scl_in = 1'b1; tick(T1 + 10);
    expect_at("R9", 1, 3'b110, 3'b111);
    tick(2);

    if_rst = 1'b1;
    expect_at("R10", 1, 3'b000, 3'b110);
    tick(1); if_rst = 1'b0; tick(2);

    tick(T0 + 50);
    expect_at("R5", 1, 3'b000, 3'b111);
    tick(2);

    do_start();
    expect_at("R2", 1, 3'b100, 3'b100);
    tick(2);
    period_sel = 1'b1;
    scl_in = 1'b1;
    expect_at("R4", T1 + 2, 3'b100, 3'b111);
    expect_at("R4", T1 + 3, 3'b111, 3'b111);
    tick(T1 + 4);
    irq_ack = 1'b1;
    expect_at("R8", 1, 3'b110, 3'b111);
    tick(1); irq_ack = 1'b0; tick(2);

    if_en = 1'b0;
    expect_at("R10", 1, 3'b000, 3'b111);
    tick(1); if_en = 1'b1; tick(2);

    do_start();
    period_sel = 1'b0;
    scl_in = 1'b1; tick(1000);
    scl_in = 1'b0; tick(3);
    scl_in = 1'b1;
    expect_at("R7", T0 + 2, 3'b100, 3'b111);
    expect_at("R7", T0 + 3, 3'b111, 3'b111);
    tick(T0 + 4);

    if_rst = 1'b1; irq_clr = 1'b1; tick(1);
    if_rst = 1'b0; irq_clr = 1'b0; tick(2);
    do_start();
    det_en = 1'b0;
    scl_in = 1'b1; tick(T0 + 100);
    expect_at("R6", 1, 3'b100, 3'b111);
    tick(2);
    det_en = 1'b1; tick(500);
    det_en = 1'b0; tick(1);
    det_en = 1'b1;
    expect_at("R6", T0, 3'b100, 3'b111);
    expect_at("R6", T0 + 1, 3'b111, 3'b111);
    tick(T0 + 3);
    det_en = 1'b0; tick(3);
    expect_at("R6", 1, 3'b111, 3'b111);
    tick(2);
    det_en = 1'b1;

    if_rst = 1'b1; irq_clr = 1'b1; tick(1);
    if_rst = 1'b0; irq_clr = 1'b0; tick(2);
    expect_at("R10", 1, 3'b000, 3'b111);
    tick(2);
    do_start();
    scl_in = 1'b1; tick(T0 + 2);
    irq_ack = 1'b1;
    expect_at("R11", 1, 3'b111, 3'b111);
    tick(1); irq_ack = 1'b0; tick(2);

    sda_in = 1'b1;
    expect_at("R2", 2, 3'b100, 3'b100);
    expect_at("R2", 3, 3'b000, 3'b100);
    tick(5);

    if (q.size() != 0) begin
      failures++;
      $display("FAIL scoreboard left %0d unchecked items", q.size());
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule